// File: doc/BRIEF.md
# Bit-serial binary field multiplier

This block multiplies two elements of the binary extension field GF(2^M) held in polynomial basis. Bit i of an operand is the coefficient of x^i. The product is reduced modulo a fixed irreducible polynomial `POLY`, which is given as a parameter. The default configuration is M = 233 with x^233 + x^74 + 1.

A caller presents both operands and pulses `start` while the block is idle. The block copies the operands into internal registers. It then walks the second operand from its top coefficient down to coefficient zero, handling one coefficient per clock. On each step the partial result is shifted up by one, the first operand is added in when the current coefficient is one, and the polynomial is folded back in when the shift overflows past degree M-1. Because of this, no separate reduction pass follows the loop. When the last coefficient has been handled, `product` is updated and `done` pulses for one cycle.

The block is meant to be the inner multiplier of a larger point-arithmetic engine. It trades cycles for area, since there is a single M-bit accumulator and no partial-product array.

Top module: `gfm_mul`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `busy` is 0, `done` is 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is low captures `a_in` and `b_in`, and `busy` is 1 from the next cycle.
- R3: If the edge that captures `start` is edge 0, then `busy` falls and `done` is 1 after edge M. The whole operation spans M+1 edges, and `done` is high for exactly one cycle.
- R4: After `done`, `product` equals `a_in`·`b_in` reduced modulo `POLY` over GF(2), using the operands that were captured at start.
- R5: Identity and zero hold. Taking `b_in` = 1 (only bit 0 set) gives `product` = `a_in`, and taking `b_in` = 0 gives `product` = 0.
- R6: A `start` pulse that arrives while `busy` is 1 is ignored. The running operation keeps its timing and its result.
- R7: `product` changes only on the edge that raises `done`. Changes on `a_in` and `b_in` after capture have no effect.
- R8: A `start` that is high in the same cycle that `done` is high begins a new operation at once.
- R9: Overflow is reduced correctly. Taking `a_in` = x^(M-1) (only bit M-1 set) and `b_in` = x (only bit 1 set) gives `product` = `POLY` without its top bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication when idle |
| a_in | input | M | First operand |
| b_in | input | M | Second operand, scanned top bit first |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse when `product` is updated |
| product | output | M | Reduced product |

## Verification
A wrong step counter or a lost start shows up as `busy` or `done` moving on the wrong cycle. The bench model catches this on the first clock where the two differ, which is M+1 cycles after start at the latest. A fault in the accumulator, such as a skipped reduction, a wrong bit scan order or a stale first operand, can only be seen in `product` once `done` fires. It is therefore checked at that edge against an independent carry-less multiply and reduction. Overflow and identity operands are chosen so that each fault gives a distinct wrong word.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
  typedef enum logic {GFM_IDLE, GFM_RUN} gfm_state_t;
endpackage

// File: rtl/gfm_ctrl.sv
module gfm_ctrl #(
  parameter int M = 233
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic busy,
  output logic done
);
  import gfm_pkg::*;
  localparam int CW = (M > 2) ? $clog2(M) : 1;

  gfm_state_t      state;
  logic [CW-1:0]   cnt;

  assign busy = (state == GFM_RUN);
  assign load = start & ~busy;
  assign step = busy;
  assign last = busy & (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= GFM_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        state <= GFM_RUN;
        cnt   <= CW'(M - 1);
      end else if (busy) begin
        if (last) begin
          state <= GFM_IDLE;
          done  <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3
  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done)); // R6
endmodule

// File: rtl/gfm_bscan.sv
module gfm_bscan #(
  parameter int M = 233
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [M-1:0] b_in,
  output logic         bit_cur
);
  logic [M-1:0] sr;

  assign bit_cur = sr[M-1];

  always_ff @(posedge clk) begin
    if (rst)       sr <= '0;
    else if (load) sr <= b_in;
    else if (step) sr <= {sr[M-2:0], 1'b0};
  end
endmodule

// File: rtl/gfm_accum.sv
module gfm_accum #(
  parameter int         M    = 233,
  parameter logic [M:0] POLY = ((M+1)'(1) << M) | ((M+1)'(1) << 74) | (M+1)'(1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic         last,
  input  logic         bit_cur,
  input  logic [M-1:0] a_in,
  output logic [M-1:0] product
);
  logic [M-1:0] a_q;
  logic [M-1:0] acc;
  logic [M:0]   shifted;
  logic [M-1:0] acc_next;

  always_comb begin
    shifted  = {acc, 1'b0} ^ {1'b0, (bit_cur ? a_q : {M{1'b0}})};
    acc_next = shifted[M-1:0] ^ (shifted[M] ? POLY[M-1:0] : {M{1'b0}});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q     <= '0;
      acc     <= '0;
      product <= '0;
    end else if (load) begin
      a_q <= a_in;
      acc <= '0;
    end else if (step) begin
      acc <= acc_next;
      if (last) product <= acc_next;
    end
  end
endmodule

// File: rtl/gfm_mul.sv
module gfm_mul #(
  parameter int         M    = 233,
  parameter logic [M:0] POLY = ((M+1)'(1) << M) | ((M+1)'(1) << 74) | (M+1)'(1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [M-1:0] a_in,
  input  logic [M-1:0] b_in,
  output logic         busy,
  output logic         done,
  output logic [M-1:0] product
);
  localparam int LW = $clog2(M + 1) + 1;

  logic load, step, last, bit_cur;

  gfm_ctrl #(.M(M)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .load(load), .step(step),
    .last(last), .busy(busy), .done(done)
  );

  gfm_bscan #(.M(M)) u_bscan (
    .clk(clk), .rst(rst), .load(load), .step(step), .b_in(b_in),
    .bit_cur(bit_cur)
  );

  gfm_accum #(.M(M), .POLY(POLY)) u_accum (
    .clk(clk), .rst(rst), .load(load), .step(step), .last(last),
    .bit_cur(bit_cur), .a_in(a_in), .product(product)
  );

  logic [LW-1:0] run_len;
  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_len == LW'(M))); // R3
  AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product)); // R7
endmodule

// File: tb/sim_gfm_mul.sv
`timescale 1ns/1ps
module sim_gfm_mul;
  localparam int         M    = 233;
  localparam logic [M:0] POLY = ((M+1)'(1) << M) | ((M+1)'(1) << 74) | (M+1)'(1);
  localparam int         NW   = (M + 31) / 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [M-1:0] a_in = '0;
  logic [M-1:0] b_in = '0;
  logic         busy, done;
  logic [M-1:0] product;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gfm_mul #(.M(M), .POLY(POLY)) u0 (
    .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
    .busy(busy), .done(done), .product(product)
  );

  function automatic logic [M-1:0] gf_ref(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [2*M-1:0] full;
    full = '0;
    for (int i = 0; i < M; i++)
      if (b[i]) full = full ^ ({{M{1'b0}}, a} << i);
    for (int k = 2*M-2; k >= M; k--)
      if (full[k]) full = full ^ ({{(M-1){1'b0}}, POLY} << (k - M));
    return full[M-1:0];
  endfunction

  function automatic logic [M-1:0] rnd();
    logic [NW*32-1:0] t;
    for (int w = 0; w < NW; w++) t[w*32 +: 32] = $urandom;
    return t[M-1:0];
  endfunction

  // cycle-level reference model
  logic         m_busy = 1'b0, m_done = 1'b0;
  logic [M-1:0] m_prod = '0, m_pend = '0;
  int           m_cnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 1'b0; m_done = 1'b0; m_prod = '0; m_cnt = 0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == M) begin
          m_busy = 1'b0; m_done = 1'b1; m_prod = m_pend;
        end
      end else if (start) begin
        m_busy = 1'b1; m_cnt = 0; m_pend = gf_ref(a_in, b_in);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (busy !== m_busy || done !== m_done) begin
        errors++;
        $display("FAIL R3 cycle busy/done actual %b/%b expected %b/%b", busy, done, m_busy, m_done);
      end
      checks++;
      if (product !== m_prod) begin
        errors++;
        $display("FAIL R7 cycle product actual %h expected %h", product, m_prod);
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [M-1:0] a, input logic [M-1:0] b, input string req,
                        input bit b2b, input int inject);
    logic [M-1:0] exp;
    int n;
    if (!b2b) @(negedge clk);
    start = 1'b1; a_in = a; b_in = b;
    exp = gf_ref(a, b);
    @(negedge clk);
    n = 1;
    start = 1'b0; a_in = rnd(); b_in = rnd();
    check(busy === 1'b1, "R2 busy after capture", M'(busy), M'(1));
    while (!done && n <= M + 10) begin
      start = (n == inject);
      if (n == inject) begin a_in = rnd(); b_in = rnd(); end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check(n == M + 1, "R3 latency", M'(n), M'(M + 1));
    check(product === exp, req, product, exp);
  endtask

  initial begin
    logic [M-1:0] a, held;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 reset flags", M'({busy, done}), '0);
    check(product === '0, "R1 reset product", product, '0);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && product === '0, "R1 after reset", product, '0);

    a = rnd();
    run_op(a, M'(1), "R5 identity", 1'b0, 0);
    check(product === a, "R5 identity equals a_in", product, a);
    run_op(rnd(), '0, "R5 zero", 1'b0, 0);
    check(product === '0, "R5 zero product", product, '0);
    run_op(M'(1) << (M-1), M'(2), "R9 overflow", 1'b0, 0);
    check(product === POLY[M-1:0], "R9 overflow equals poly", product, POLY[M-1:0]);
    run_op({M{1'b1}}, {M{1'b1}}, "R4 all ones", 1'b0, 0);
    for (int i = 0; i < 6; i++) run_op(rnd(), rnd(), "R4 random", 1'b0, 0);
    run_op(rnd(), rnd(), "R6 start while busy", 1'b0, 5);
    run_op(rnd(), rnd(), "R6 start near end", 1'b0, M);
    run_op(rnd(), rnd(), "R8 first", 1'b0, 0);
    run_op(rnd(), rnd(), "R8 back to back", 1'b1, 0);

    held = product;
    for (int i = 0; i < 20; i++) begin
      a_in = rnd(); b_in = rnd();
      @(negedge clk);
    end
    check(product === held && busy === 1'b0, "R7 idle hold", product, held);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule